// File: doc/BRIEF.md
# Two-Wire Configuration Register Target

This block is the serial target for a bank of configuration registers. A controller on a two-wire bus (clock line and data line, each pulled low by whoever talks and pulled high otherwise) addresses it by its 7-bit device code. The controller then sends a command byte. Bit 7 of that byte picks single-register or sequential access. Bits 6:0 give the starting register index. After the command byte the controller either writes data or issues a repeated START with the read direction. The block oversamples both lines on its own clock. It needs no clock from the bus.

Written bytes take effect during their own acknowledge bit, so the bank drives the configuration outputs with no extra staging. An input from a non-volatile store marks a programming cycle. While that input is high, the block refuses write data but still answers reads. One register bit shows the same flag back to the controller.

There is no streaming data at the block's edge. The bus is the only data path and it has no back-pressure, because clock stretching is not supported. Every pin is a plain control or status level.

Top module: `smb_cfg_target`

## Requirements
- R1: The target acknowledges only the device address {1,1,0,1,0,strap_i[1],strap_i[0]} (bit 6 down to bit 0). On any other address it leaves the data line released for that byte and for the rest of the transfer.
- R2: The direction bit after the address is 0 for write and 1 for read. In a write, the first byte after the address is the command and is always acknowledged. A read starts at the register selected by the last command.
- R3: A command with bit 7 = 1 is a single access. Exactly one data byte is written, and any further write byte is NACKed and dropped. Reads return the same register again and again without advancing.
- R4: A command with bit 7 = 0 is a sequential access. Bytes go to or come from ascending registers starting at the offset. The controller may end after any complete byte, and registers it did not reach keep their values.
- R5: Command bits 6:0 are the starting offset. At offset NUM_REGS or above (including after running off the end), write bytes are NACKed and reads return 8'h00.
- R6: Data moves most significant bit first in both directions.
- R7: An accepted write byte is visible on cfg_o while the acknowledge clock is still high. Without a write, the stored register contents do not change.
- R8: While nvm_busy_i is 1, the address and command are still acknowledged. Write data bytes are NACKed and leave the registers unchanged, and reads return normal contents.
- R9: Register 24 bit 7 reads as nvm_busy_i, and writes to it are ignored. The other bits of register 24 are writable.
- R10: At reset, register i holds ((i*29) mod 256) XOR 8'h5A, except that register 24 bit 7 shows nvm_busy_i. sda_pull_o is 0 at reset.
- R11: A START or repeated START restarts address reception, even in the middle of a byte, and a partial byte writes nothing. A STOP returns to idle. A controller NACK after a read byte ends the read, and the target stays released until the next START.
- R12: sda_pull_o changes only while the synchronised clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 2 | Low two bits of the device address |
| nvm_busy_i | input | 1 | Non-volatile programming cycle in progress |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| cfg_o | output | NUM_REGS*8 | Register contents, register i at bits [8i+7:8i] |

## Verification
Several properties are checked on every cycle by assertions:
- the pull output moves only while the clock line is low;
- the pull is asserted only in an acknowledge slot or a read bit, and never while idle or ignoring;
- no write strobe occurs while the store is busy or out of range;
- stored contents move only on a write strobe.

Other behaviour only the bench scenarios can show:
- address filtering against the straps;
- the single versus sequential walk of the register index;
- early termination, repeated START in mid-byte and the controller's NACK;
- the exact bit order and the values read back.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

  typedef enum logic [2:0] {
    LS_IDLE,
    LS_ADDR,
    LS_CMD,
    LS_WR,
    LS_RD,
    LS_SKIP
  } link_st_t;

  function automatic logic [7:0] reg_default(input int idx);
    reg_default = 8'(idx * 29) ^ 8'h5A;
  endfunction

endpackage

// File: rtl/smb_edge_sync.sv
module smb_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh   <= '1;
      sda_sh   <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_sh   <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh   <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_prev <= scl_sh[SYNC_STAGES-1];
      sda_prev <= sda_sh[SYNC_STAGES-1];
    end
  end

  assign scl_lvl   = scl_sh[SYNC_STAGES-1];
  assign sda_lvl   = sda_sh[SYNC_STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/smb_cfg_regs.sv
module smb_cfg_regs
  import smb_cfg_pkg::*;
#(
  parameter int NUM_REGS   = 32,
  parameter int STATUS_IDX = 24,
  parameter int STATUS_BIT = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [6:0]            wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [6:0]            rd_idx,
  input  logic                  nvm_busy,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] cfg_flat
);

  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [7:0] NREG8 = 8'(NUM_REGS);
  localparam logic [7:0] STAT_MASK = 8'(1 << STATUS_BIT);

  logic [7:0] store [NUM_REGS];
  logic [7:0] view  [NUM_REGS];
  logic [NUM_REGS*8-1:0] store_flat;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [7:0] KEEP = (g == STATUS_IDX) ? ~STAT_MASK : 8'hFF;
    localparam logic [7:0] SHOW = (g == STATUS_IDX) ? STAT_MASK : 8'h00;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        store[g] <= reg_default(g) & KEEP;
      else if (wr_en && wr_idx == 7'(g))
        store[g] <= wr_data & KEEP;
    end

    assign view[g] = store[g] | (nvm_busy ? SHOW : 8'h00);
    assign cfg_flat[g*8 +: 8]   = view[g];
    assign store_flat[g*8 +: 8] = store[g];
  end

  always_comb begin
    if ({1'b0, rd_idx} < NREG8)
      rd_data = view[rd_idx[IDX_W-1:0]];
    else
      rd_data = 8'h00;
  end

  // R7: contents move only on a write strobe
  p_store_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(store_flat));

  // R5: no strobe outside the bank
  p_wr_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ({1'b0, wr_idx} < NREG8));

endmodule

// File: rtl/smb_link_fsm.sv
module smb_link_fsm
  import smb_cfg_pkg::*;
#(
  parameter int          NUM_REGS = 32,
  parameter logic [4:0]  ADDR_HI  = 5'b11010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_lvl,
  input  logic       sda_lvl,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [1:0] strap,
  input  logic       nvm_busy,
  input  logic [7:0] rd_data,
  output logic [6:0] rd_idx,
  output logic       wr_en,
  output logic [6:0] wr_idx,
  output logic [7:0] wr_data,
  output logic       sda_pull
);

  localparam logic [7:0] NREG8 = 8'(NUM_REGS);

  link_st_t   st_q, nxt_q;
  logic [3:0] bitcnt_q;
  logic       in_ack_q;
  logic [7:0] shreg_q, tx_q;
  logic [6:0] ptr_q;
  logic       single_q, wrote_q, commit_q, pull_q;
  logic       wr_en_q;
  logic [6:0] wr_idx_q;
  logic [7:0] wr_data_q;
  logic       addr_hit, wr_ok;

  assign addr_hit = (shreg_q[7:1] == {ADDR_HI, strap});
  assign wr_ok    = ({1'b0, ptr_q} < NREG8) && !nvm_busy && !(single_q && wrote_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= LS_IDLE;
      nxt_q     <= LS_IDLE;
      bitcnt_q  <= '0;
      in_ack_q  <= 1'b0;
      shreg_q   <= '0;
      tx_q      <= '0;
      ptr_q     <= '0;
      single_q  <= 1'b0;
      wrote_q   <= 1'b0;
      commit_q  <= 1'b0;
      pull_q    <= 1'b0;
      wr_en_q   <= 1'b0;
      wr_idx_q  <= '0;
      wr_data_q <= '0;
    end else begin
      wr_en_q <= 1'b0;
      if (start_det) begin
        st_q     <= LS_ADDR;
        bitcnt_q <= '0;
        in_ack_q <= 1'b0;
        commit_q <= 1'b0;
        pull_q   <= 1'b0;
      end else if (stop_det) begin
        st_q     <= LS_IDLE;
        bitcnt_q <= '0;
        in_ack_q <= 1'b0;
        commit_q <= 1'b0;
        pull_q   <= 1'b0;
      end else if (st_q == LS_IDLE || st_q == LS_SKIP) begin
        pull_q <= 1'b0;
      end else if (scl_rise) begin
        if (!in_ack_q) begin
          shreg_q <= {shreg_q[6:0], sda_lvl};
          if (bitcnt_q != 4'd8) bitcnt_q <= bitcnt_q + 4'd1;
        end else begin
          case (st_q)
            LS_WR: if (commit_q && !nvm_busy) begin
              wr_en_q   <= 1'b1;
              wr_idx_q  <= ptr_q;
              wr_data_q <= shreg_q;
              wrote_q   <= 1'b1;
              commit_q  <= 1'b0;
              if (!single_q) ptr_q <= ptr_q + 7'd1;
            end
            LS_RD: begin
              if (sda_lvl) nxt_q <= LS_SKIP;
              else if (!single_q) ptr_q <= ptr_q + 7'd1;
            end
            default: ;
          endcase
        end
      end else if (scl_fall) begin
        if (in_ack_q) begin
          in_ack_q <= 1'b0;
          bitcnt_q <= '0;
          commit_q <= 1'b0;
          st_q     <= nxt_q;
          if (nxt_q == LS_RD) begin
            tx_q   <= rd_data;
            pull_q <= ~rd_data[7];
          end else begin
            pull_q <= 1'b0;
          end
        end else if (bitcnt_q == 4'd8) begin
          in_ack_q <= 1'b1;
          case (st_q)
            LS_ADDR: begin
              pull_q <= addr_hit;
              nxt_q  <= !addr_hit ? LS_SKIP : (shreg_q[0] ? LS_RD : LS_CMD);
            end
            LS_CMD: begin
              pull_q   <= 1'b1;
              ptr_q    <= shreg_q[6:0];
              single_q <= shreg_q[7];
              wrote_q  <= 1'b0;
              nxt_q    <= LS_WR;
            end
            LS_WR: begin
              pull_q   <= wr_ok;
              commit_q <= wr_ok;
              nxt_q    <= wr_ok ? LS_WR : LS_SKIP;
            end
            default: begin
              pull_q <= 1'b0;
              nxt_q  <= LS_RD;
            end
          endcase
        end else if (st_q == LS_RD && bitcnt_q != 4'd0) begin
          pull_q <= ~tx_q[6];
          tx_q   <= {tx_q[6:0], 1'b0};
        end
      end
    end
  end

  assign rd_idx   = ptr_q;
  assign wr_en    = wr_en_q;
  assign wr_idx   = wr_idx_q;
  assign wr_data  = wr_data_q;
  assign sda_pull = pull_q;

  // R12: data line moves only while clock is low
  p_pull_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pull_q) |-> !scl_lvl);

  // R1: pulling outside read data happens only in an acknowledge slot
  p_ack_slot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_q && st_q != LS_RD) |-> in_ack_q);

  // R8: a busy store never sees a write strobe
  p_busy_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (nvm_busy && $past(nvm_busy)) |-> !wr_en_q);

  // R11: idle or ignoring means released
  p_quiet_when_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LS_IDLE || st_q == LS_SKIP) |-> !pull_q);

endmodule

// File: rtl/smb_cfg_target.sv
module smb_cfg_target
  import smb_cfg_pkg::*;
#(
  parameter int         NUM_REGS    = 32,
  parameter int         STATUS_IDX  = 24,
  parameter int         STATUS_BIT  = 7,
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] ADDR_HI     = 5'b11010
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic [1:0]            strap_i,
  input  logic                  nvm_busy_i,
  output logic                  sda_pull_o,
  output logic [NUM_REGS*8-1:0] cfg_o
);

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0] rd_data, wr_data;
  logic [6:0] rd_idx, wr_idx;
  logic wr_en;

  smb_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  smb_link_fsm #(.NUM_REGS(NUM_REGS), .ADDR_HI(ADDR_HI)) u_link (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .strap(strap_i), .nvm_busy(nvm_busy_i),
    .rd_data(rd_data), .rd_idx(rd_idx), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .sda_pull(sda_pull_o)
  );

  smb_cfg_regs #(.NUM_REGS(NUM_REGS), .STATUS_IDX(STATUS_IDX),
                 .STATUS_BIT(STATUS_BIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .nvm_busy(nvm_busy_i),
    .rd_data(rd_data), .cfg_flat(cfg_o)
  );

endmodule

// File: tb/sim_smb_cfg_target.sv
module sim_smb_cfg_target;

  localparam int CLK_PER  = 10;
  localparam int QCLK     = 8;
  localparam int NREGS    = 32;
  localparam logic [6:0] MY_ADDR = 7'b1101010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_line = 1'b1;
  logic ctl_low = 1'b0;
  logic [1:0] strap = 2'b10;
  logic busy = 1'b0;
  logic sda_pull;
  logic [NREGS*8-1:0] cfg;
  wire  sda_line = !(ctl_low || sda_pull);

  int n_chk = 0;
  int n_bad = 0;
  int r12_viol = 0;
  logic [7:0] mid_ack_cfg;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] got_q[$];

  always #(CLK_PER/2) clk = ~clk;

  smb_cfg_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .strap_i(strap), .nvm_busy_i(busy), .sda_pull_o(sda_pull), .cfg_o(cfg)
  );

  function automatic logic [7:0] def_val(input int i);
    logic [7:0] v;
    v = 8'((i * 29) % 256) ^ 8'h5A;
    if (i == 24) v = v & 8'h7F;
    return v;
  endfunction

  function automatic logic [7:0] reg_at(input int i);
    return cfg[i*8 +: 8];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R12 monitor on the bus
  logic pull_d = 1'b0;
  always @(negedge clk) begin
    if (sda_pull !== pull_d && scl_line) r12_viol++;
    pull_d <= sda_pull;
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (got_q.size() > 0 && exp_q.size() > 0) begin
        automatic logic [7:0] g = got_q.pop_front();
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, {24'h0, g}, {24'h0, e});
      end
    end
  end

  task automatic wq();
    repeat (QCLK) @(negedge clk);
  endtask

  task automatic bus_start();
    ctl_low = 1'b0; wq();
    scl_line = 1'b1; wq();
    ctl_low = 1'b1; wq();
    scl_line = 1'b0; wq();
  endtask

  task automatic bus_stop();
    ctl_low = 1'b1; wq();
    scl_line = 1'b1; wq();
    ctl_low = 1'b0; wq();
  endtask

  task automatic put_bit(input logic b);
    ctl_low = !b; wq();
    scl_line = 1'b1; wq(); wq();
    scl_line = 1'b0; wq();
  endtask

  task automatic get_bit(output logic b);
    ctl_low = 1'b0; wq();
    scl_line = 1'b1; wq();
    b = sda_line; wq();
    scl_line = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] d, input int snap_idx, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    ctl_low = 1'b0; wq();
    scl_line = 1'b1; wq();
    ack = !sda_line;
    if (snap_idx >= 0) mid_ack_cfg = reg_at(snap_idx);
    wq();
    scl_line = 1'b0; wq();
  endtask

  task automatic recv_byte(input logic ack);
    logic [7:0] d;
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    got_q.push_back(d);
    put_bit(!ack);
  endtask

  task automatic expect_rd(input logic [7:0] v, input string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  task automatic set_ptr(input logic [7:0] cmd, input string t);
    logic a;
    bus_start();
    send_byte({MY_ADDR, 1'b0}, -1, a); chk({t, " addr ack"}, a, 1);
    send_byte(cmd, -1, a);             chk({t, " cmd ack R2"}, a, 1);
  endtask

  task automatic read_n(input logic [7:0] cmd, input int n, input string t);
    logic a;
    set_ptr(cmd, t);
    bus_start();
    send_byte({MY_ADDR, 1'b1}, -1, a); chk({t, " read addr ack R2"}, a, 1);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1);
    bus_stop();
    wq();
  endtask

  initial begin
    logic a;
    logic b;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    wq();

    // R10 reset state
    for (int i = 0; i < NREGS; i++) chk("R10 default", reg_at(i), def_val(i));
    chk("R10 pull idle", sda_pull, 0);

    // R1 R6 R7 single write of reg 3
    set_ptr(8'h83, "R1");
    send_byte(8'hC4, 3, a);
    chk("R7 ack", a, 1);
    chk("R7 mid-ack value", mid_ack_cfg, 8'hC4);
    bus_stop();
    chk("R6 msb first write", reg_at(3), 8'hC4);

    // R2 R6 single read
    expect_rd(8'hC4, "R6 read reg3");
    read_n(8'h83, 1, "R2");

    // R1 foreign address ignored
    bus_start();
    send_byte({7'b1101001, 1'b0}, -1, a); chk("R1 foreign addr nack", a, 0);
    send_byte(8'h83, -1, a);              chk("R1 cmd ignored", a, 0);
    send_byte(8'h00, -1, a);              chk("R1 data ignored", a, 0);
    bus_stop();
    chk("R1 reg untouched", reg_at(3), 8'hC4);

    // R4 block write and read
    set_ptr(8'h05, "R4");
    for (int i = 0; i < 4; i++) begin
      send_byte(8'(8'h11 * (i + 1)), -1, a);
      chk("R4 block ack", a, 1);
    end
    bus_stop();
    for (int i = 0; i < 4; i++) chk("R4 block reg", reg_at(5 + i), 8'(8'h11 * (i + 1)));
    for (int i = 0; i < 4; i++) expect_rd(8'(8'h11 * (i + 1)), "R4 block read");
    read_n(8'h05, 4, "R4");

    // R4 early stop
    set_ptr(8'h0A, "R4");
    send_byte(8'hAB, -1, a);
    send_byte(8'hCD, -1, a);
    bus_stop();
    chk("R4 early reg10", reg_at(10), 8'hAB);
    chk("R4 early reg11", reg_at(11), 8'hCD);
    chk("R4 reg12 untouched", reg_at(12), def_val(12));

    // R3 single mode second byte
    set_ptr(8'h83, "R3");
    send_byte(8'h55, -1, a); chk("R3 first ack", a, 1);
    send_byte(8'h66, -1, a); chk("R3 second nack", a, 0);
    bus_stop();
    chk("R3 reg3", reg_at(3), 8'h55);
    chk("R3 reg4 untouched", reg_at(4), def_val(4));
    expect_rd(8'h55, "R3 repeat read 1");
    expect_rd(8'h55, "R3 repeat read 2");
    read_n(8'h83, 2, "R3");

    // R5 out of range
    set_ptr(8'hA8, "R5");
    send_byte(8'h12, -1, a); chk("R5 oob write nack", a, 0);
    bus_stop();
    expect_rd(8'h00, "R5 oob read");
    read_n(8'hA8, 1, "R5");
    set_ptr(8'h1F, "R5");
    send_byte(8'h77, -1, a); chk("R5 last reg ack", a, 1);
    send_byte(8'h88, -1, a); chk("R5 past end nack", a, 0);
    bus_stop();
    chk("R5 last reg", reg_at(31), 8'h77);

    // R8 R9 busy
    busy = 1'b1;
    set_ptr(8'h94, "R8");
    send_byte(8'h99, -1, a); chk("R8 busy data nack", a, 0);
    bus_stop();
    chk("R8 reg20 untouched", reg_at(20), def_val(20));
    expect_rd(def_val(24) | 8'h80, "R9 busy flag read");
    read_n(8'h98, 1, "R9");
    expect_rd(8'h11, "R8 read while busy");
    read_n(8'h85, 1, "R8");
    busy = 1'b0;
    wq();

    // R9 flag read-only
    set_ptr(8'h98, "R9");
    send_byte(8'hFF, -1, a); chk("R9 write ack", a, 1);
    bus_stop();
    expect_rd(8'h7F, "R9 flag ignores write");
    read_n(8'h98, 1, "R9");

    // R11 repeated start mid-byte
    set_ptr(8'h8A, "R11");
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_start();
    send_byte({MY_ADDR, 1'b1}, -1, a); chk("R11 restart addr ack", a, 1);
    expect_rd(8'hAB, "R11 partial byte not written");
    recv_byte(1'b0);
    for (int i = 0; i < 9; i++) begin
      get_bit(b);
      chk("R11 released after nack", b, 1);
    end
    bus_stop();
    wq();

    chk("R12 pull moved with scl high", r12_viol, 0);
    repeat (20) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PER * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule